// File: doc/BRIEF.md
# Periodic Rate Generator

This block turns a reference tick into a programmable periodic event and a square-wave pin level. A mode field picks how many reference ticks make one tick of a 32768 Hz base, or stops the chain: two of its values clear the divider stages, and three others freeze them. A fourteen-stage binary chain counts base ticks. A four-bit rate code then picks one chain stage as the output tap.

Each rising edge of the chosen tap produces a one-cycle event pulse. An interrupt request copies that pulse while the interrupt enable is set. The square-wave pin shows the tap level while the square-wave enable is set. Rate code 0 turns both the event and the pin off. Code 1 runs at the full base rate. Code 15 runs at 2 Hz.

Top module: `pir_rate_gen`

## Requirements
- R1: While `rst_n` is low, `pf_evt`, `irq_req` and `sq_out` are 0, and the prescaler, the stage chain and the code-1 toggle all return to zero.
- R2: `div_sel` values 0, 1 and 2 make one base tick from every 128, 32 and 1 reference ticks, which turns 4.194304 MHz, 1.048576 MHz and 32.768 kHz into 32768 Hz.
- R3: `div_sel` values 6 and 7 hold the prescaler and the chain at zero with no events. After the mode returns to a running value, code n of 2 or more gives its first event after 2^(n-2) base ticks.
- R4: `div_sel` values 3, 4 and 5 freeze the prescaler and the chain without clearing them and give no events. Counting resumes from the frozen state.
- R5: Rate code 0 gives no event and holds `sq_out` at 0.
- R6: Rate code n from 2 to 15 raises `pf_evt` on each rising edge of chain stage n-2. That is once every 2^(n-1) base ticks, a rate of 32768>>(n-1) Hz.
- R7: Rate code 1 raises `pf_evt` on every base tick, and the pin level toggles on every base tick.
- R8: For rate code n of 2 or more with `sqw_en` high, `sq_out` equals chain stage n-2, a 50% duty wave with a period of 2^(n-1) base ticks.
- R9: With `sqw_en` low, `sq_out` is 0 and events are unchanged.
- R10: `irq_req` equals `pf_evt` while `pie_en` is high and is 0 otherwise. `pie_en` has no effect on `pf_evt`.
- R11: `pf_evt` is a registered pulse. It is high for the one cycle after the clock edge that takes the completing reference tick. `sq_out` changes at that same edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ref_tick | input | 1 | One-cycle strobe per reference oscillator period |
| div_sel | input | 3 | Divider mode: 0/1/2 run, 3-5 freeze, 6/7 clear |
| rate_code | input | RATE_W (4) | Tap select, 0 = off |
| pie_en | input | 1 | Interrupt request enable |
| sqw_en | input | 1 | Square-wave pin enable |
| pf_evt | output | 1 | Periodic event pulse |
| irq_req | output | 1 | Gated interrupt request |
| sq_out | output | 1 | Square-wave pin level |

## Verification
A wrong prescaler count shows up within one base period (at most 128 reference ticks) as an event or pin edge in the wrong cycle. A chain stage that is stuck or skips shows up as a wrong pin level or a missed event no later than one period of the selected tap. The bench runs a behavioural model next to the design and compares all three outputs in every cycle, so any such drift is reported in the first cycle where it becomes visible. The runs include sparse reference ticks, freeze and clear intervals, and every rate code, so that faults in state that is rarely used still reach the ports.

// File: rtl/pir_pkg.sv
package pir_pkg;

   localparam int DIV_W = 3;

   typedef enum logic [1:0] {
      OP_RUN   = 2'd0,
      OP_HOLD  = 2'd1,
      OP_CLEAR = 2'd2
   } chain_op_e;

   function automatic chain_op_e div_to_op(input logic [DIV_W-1:0] d);
      chain_op_e r;
      case (d)
         3'd0, 3'd1, 3'd2: r = OP_RUN;
         3'd6, 3'd7:       r = OP_CLEAR;
         default:          r = OP_HOLD;
      endcase
      return r;
   endfunction

endpackage

// File: rtl/pir_prescale.sv
module pir_prescale
   import pir_pkg::*;
#(
   parameter int PRE_W      = 7,
   parameter int RATIO_FAST = 128,
   parameter int RATIO_MID  = 32,
   parameter int RATIO_SLOW = 1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             ref_tick,
   input  logic [DIV_W-1:0] div_sel,
   output logic             base_tick,
   output chain_op_e        op
);

   localparam logic [PRE_W-1:0] LIM_FAST = PRE_W'(RATIO_FAST - 1);
   localparam logic [PRE_W-1:0] LIM_MID  = PRE_W'(RATIO_MID - 1);
   localparam logic [PRE_W-1:0] LIM_SLOW = PRE_W'(RATIO_SLOW - 1);
   localparam bit USE_CNT = (RATIO_FAST > 1) || (RATIO_MID > 1) || (RATIO_SLOW > 1);

   if (PRE_W < 1 || PRE_W > 16) begin : g_bad_prew
      $error("pir_prescale: PRE_W out of range");
   end
   if (RATIO_FAST < 1 || RATIO_FAST > (1 << PRE_W) ||
       RATIO_MID  < 1 || RATIO_MID  > (1 << PRE_W) ||
       RATIO_SLOW < 1 || RATIO_SLOW > (1 << PRE_W)) begin : g_bad_ratio
      $error("pir_prescale: a ratio does not fit PRE_W");
   end

   assign op = div_to_op(div_sel);

   if (USE_CNT) begin : g_cnt
      logic [PRE_W-1:0] lim;
      logic [PRE_W-1:0] cnt_q;
      logic             wrap;

      always_comb begin
         case (div_sel)
            3'd0:    lim = LIM_FAST;
            3'd1:    lim = LIM_MID;
            default: lim = LIM_SLOW;
         endcase
      end

      assign wrap = (cnt_q >= lim);

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            cnt_q <= '0;
         end else if (op == OP_CLEAR) begin
            cnt_q <= '0;
         end else if (op == OP_RUN && ref_tick) begin
            cnt_q <= wrap ? '0 : cnt_q + 1'b1;
         end
      end

      assign base_tick = (op == OP_RUN) && ref_tick && wrap;
   end else begin : g_direct
      assign base_tick = (op == OP_RUN) && ref_tick;
   end

endmodule

// File: rtl/pir_stage_chain.sv
module pir_stage_chain
   import pir_pkg::*;
#(
   parameter int CHAIN_W = 14
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               base_tick,
   input  chain_op_e          op,
   output logic [CHAIN_W-1:0] stage_q,
   output logic [CHAIN_W-1:0] stage_rise,
   output logic               tog_q
);

   logic [CHAIN_W-1:0] nxt;

   if (CHAIN_W < 1) begin : g_bad_w
      $error("pir_stage_chain: CHAIN_W must be positive");
   end

   assign nxt = stage_q + 1'b1;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         stage_q <= '0;
         tog_q   <= 1'b0;
      end else if (op == OP_CLEAR) begin
         stage_q <= '0;
         tog_q   <= 1'b0;
      end else if (base_tick) begin
         stage_q <= nxt;
         tog_q   <= ~tog_q;
      end
   end

   for (genvar i = 0; i < CHAIN_W; i++) begin : g_rise
      assign stage_rise[i] = base_tick & ~stage_q[i] & nxt[i];
   end

endmodule

// File: rtl/pir_tap_select.sv
module pir_tap_select #(
   parameter int RATE_W  = 4,
   parameter int CHAIN_W = (1 << RATE_W) - 2
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic [RATE_W-1:0]  rate_code,
   input  logic               base_tick,
   input  logic [CHAIN_W-1:0] stage_q,
   input  logic [CHAIN_W-1:0] stage_rise,
   input  logic               tog_q,
   input  logic               sqw_en,
   output logic               pf_evt,
   output logic               sq_out
);

   localparam int NCODE = 1 << RATE_W;

   logic [NCODE-1:0] lvl_v;
   logic [NCODE-1:0] hit_v;

   if (CHAIN_W != NCODE - 2) begin : g_bad_chain
      $error("pir_tap_select: CHAIN_W must equal 2**RATE_W-2");
   end

   assign lvl_v[0] = 1'b0;
   assign hit_v[0] = 1'b0;
   assign lvl_v[1] = tog_q;
   assign hit_v[1] = base_tick;

   for (genvar k = 2; k < NCODE; k++) begin : g_tap
      assign lvl_v[k] = stage_q[k-2];
      assign hit_v[k] = stage_rise[k-2];
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pf_evt <= 1'b0;
      end else begin
         pf_evt <= hit_v[rate_code];
      end
   end

   assign sq_out = sqw_en & lvl_v[rate_code];

endmodule

// File: rtl/pir_rate_gen.sv
module pir_rate_gen
   import pir_pkg::*;
#(
   parameter int PRE_W      = 7,
   parameter int RATIO_FAST = 128,
   parameter int RATIO_MID  = 32,
   parameter int RATIO_SLOW = 1,
   parameter int RATE_W     = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              ref_tick,
   input  logic [DIV_W-1:0]  div_sel,
   input  logic [RATE_W-1:0] rate_code,
   input  logic              pie_en,
   input  logic              sqw_en,
   output logic              pf_evt,
   output logic              irq_req,
   output logic              sq_out
);

   localparam int CHAIN_W = (1 << RATE_W) - 2;

   if (RATE_W < 2 || RATE_W > 5) begin : g_bad_rate
      $error("pir_rate_gen: RATE_W must lie in 2..5");
   end

   logic               base_tick;
   chain_op_e          op;
   logic [CHAIN_W-1:0] stage_q;
   logic [CHAIN_W-1:0] stage_rise;
   logic               tog_q;

   pir_prescale #(
      .PRE_W      (PRE_W),
      .RATIO_FAST (RATIO_FAST),
      .RATIO_MID  (RATIO_MID),
      .RATIO_SLOW (RATIO_SLOW)
   ) u_pre (
      .clk       (clk),
      .rst_n     (rst_n),
      .ref_tick  (ref_tick),
      .div_sel   (div_sel),
      .base_tick (base_tick),
      .op        (op)
   );

   pir_stage_chain #(
      .CHAIN_W (CHAIN_W)
   ) u_chain (
      .clk        (clk),
      .rst_n      (rst_n),
      .base_tick  (base_tick),
      .op         (op),
      .stage_q    (stage_q),
      .stage_rise (stage_rise),
      .tog_q      (tog_q)
   );

   pir_tap_select #(
      .RATE_W  (RATE_W),
      .CHAIN_W (CHAIN_W)
   ) u_tap (
      .clk        (clk),
      .rst_n      (rst_n),
      .rate_code  (rate_code),
      .base_tick  (base_tick),
      .stage_q    (stage_q),
      .stage_rise (stage_rise),
      .tog_q      (tog_q),
      .sqw_en     (sqw_en),
      .pf_evt     (pf_evt),
      .sq_out     (sq_out)
   );

   assign irq_req = pf_evt & pie_en;

endmodule

// File: rtl/pir_rate_gen_chk.sv
module pir_rate_gen_chk #(
   parameter int RATE_W = 4
) (
   input logic              clk,
   input logic              rst_n,
   input logic              ref_tick,
   input logic [2:0]        div_sel,
   input logic [RATE_W-1:0] rate_code,
   input logic              pie_en,
   input logic              sqw_en,
   input logic              pf_evt,
   input logic              irq_req,
   input logic              sq_out
);

   AST_CLEAR_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      (div_sel >= 3'd6) |=> !pf_evt); // R3

   AST_HOLD_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      (div_sel >= 3'd3 && div_sel <= 3'd5) |=> !pf_evt); // R4

   AST_CODE0_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      (rate_code == '0) |=> !pf_evt); // R5

   AST_PIN_MOVES_ON_TICK: assert property (@(posedge clk) disable iff (!rst_n)
      ($changed(sq_out) && $stable(rate_code) && $stable(sqw_en) && ($past(div_sel) < 3'd3))
      |-> $past(ref_tick)); // R8

   AST_IRQ_GATED: assert property (@(posedge clk) disable iff (!rst_n)
      irq_req |-> (pf_evt && pie_en)); // R10

   AST_EVT_NEEDS_TICK: assert property (@(posedge clk) disable iff (!rst_n)
      pf_evt |-> $past(ref_tick)); // R11

endmodule

bind pir_rate_gen pir_rate_gen_chk #(.RATE_W(RATE_W)) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .ref_tick  (ref_tick),
   .div_sel   (div_sel),
   .rate_code (rate_code),
   .pie_en    (pie_en),
   .sqw_en    (sqw_en),
   .pf_evt    (pf_evt),
   .irq_req   (irq_req),
   .sq_out    (sq_out)
);

// File: tb/sim_pir_rate_gen.sv
module sim_pir_rate_gen;

   localparam int CLK_PERIOD = 10;
   localparam int CHAIN_MOD  = 16384;
   localparam int WD_LIMIT   = 150000;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       ref_tick = 1'b0;
   logic [2:0] div_sel = 3'd2;
   logic [3:0] rate_code = 4'd0;
   logic       pie_en = 1'b0;
   logic       sqw_en = 1'b0;
   logic       pf_evt, irq_req, sq_out;

   int total = 0;
   int bad = 0;
   int cyc = 0;
   string req_evt = "R1";
   string req_pin = "R1";

   int m_p = 0, m_c = 0, m_tog = 0, m_evt = 0;

   always #(CLK_PERIOD/2) clk = ~clk;

   pir_rate_gen u0 (
      .clk(clk), .rst_n(rst_n), .ref_tick(ref_tick), .div_sel(div_sel),
      .rate_code(rate_code), .pie_en(pie_en), .sqw_en(sqw_en),
      .pf_evt(pf_evt), .irq_req(irq_req), .sq_out(sq_out)
   );

   // behavioural reference: prescale count, base counter, toggle, event
   always @(posedge clk) begin
      int lim;
      int old;
      int rc;
      rc = int'(rate_code);
      if (!rst_n || div_sel >= 3'd6) begin
         m_p = 0; m_c = 0; m_tog = 0; m_evt = 0;
      end else if (div_sel >= 3'd3) begin
         m_evt = 0;
      end else begin
         lim = (div_sel == 3'd0) ? 127 : (div_sel == 3'd1) ? 31 : 0;
         m_evt = 0;
         if (ref_tick) begin
            if (m_p >= lim) begin
               m_p = 0;
               old = m_c;
               m_c = (m_c + 1) % CHAIN_MOD;
               m_tog = m_tog ^ 1;
               if (rc == 1) m_evt = 1;
               else if (rc >= 2)
                  m_evt = (((old >> (rc-2)) & 1) == 0 && ((m_c >> (rc-2)) & 1) == 1) ? 1 : 0;
            end else begin
               m_p = m_p + 1;
            end
         end
      end
   end

   task automatic check(input logic got, input int exp, input string req, input string what);
      total++;
      if (int'(got) != exp) begin
         bad++;
         $display("FAIL %s %s got=%0d exp=%0d at %0t", req, what, got, exp, $time);
      end
   endtask

   task automatic compare_all();
      int rc;
      int e_sq;
      rc = int'(rate_code);
      if (!sqw_en || rc == 0) e_sq = 0;
      else if (rc == 1) e_sq = m_tog;
      else e_sq = (m_c >> (rc-2)) & 1;
      check(pf_evt, m_evt, req_evt, "pf_evt");
      check(irq_req, (m_evt != 0 && pie_en) ? 1 : 0, "R10", "irq_req");
      check(sq_out, e_sq, req_pin, "sq_out");
   endtask

   task automatic run(input int n, input int density);
      for (int i = 0; i < n; i++) begin
         @(negedge clk);
         compare_all();
         ref_tick = (density >= 100) ? 1'b1 : (($urandom % 100) < density);
      end
   endtask

   task automatic cfg(input logic [2:0] d, input logic [3:0] rc, input logic sq, input logic pe,
                      input string re, input string rp);
      div_sel = d; rate_code = rc; sqw_en = sq; pie_en = pe;
      req_evt = re; req_pin = rp;
   endtask

   always @(posedge clk) begin
      cyc++;
      if (cyc > WD_LIMIT) begin
         bad++;
         total++;
         $display("FAIL watchdog expired after %0d cycles", cyc);
         $display("  test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

   initial begin
      // R1: outputs quiet in reset even with everything enabled
      cfg(3'd2, 4'd1, 1'b1, 1'b1, "R1", "R1");
      run(6, 100);
      @(negedge clk);
      rst_n = 1'b1;
      cfg(3'd2, 4'd3, 1'b1, 1'b1, "R6", "R8");
      run(120, 100);
      cfg(3'd2, 4'd1, 1'b1, 1'b1, "R7", "R7");
      run(60, 100);
      cfg(3'd2, 4'd0, 1'b1, 1'b1, "R5", "R5");
      run(60, 100);
      // R2: the three reference ratios
      cfg(3'd0, 4'd2, 1'b1, 1'b1, "R2", "R2");
      run(1500, 100);
      cfg(3'd1, 4'd4, 1'b1, 1'b1, "R2", "R2");
      run(3000, 60);
      cfg(3'd2, 4'd3, 1'b1, 1'b1, "R2", "R2");
      run(200, 40);
      // R3: clear, then restart from zero
      cfg(3'd6, 4'd5, 1'b1, 1'b1, "R3", "R3");
      run(20, 100);
      cfg(3'd7, 4'd5, 1'b1, 1'b1, "R3", "R3");
      run(10, 100);
      cfg(3'd2, 4'd5, 1'b1, 1'b1, "R3", "R3");
      run(200, 100);
      // R4: freeze keeps state
      cfg(3'd2, 4'd3, 1'b1, 1'b1, "R4", "R4");
      run(37, 100);
      cfg(3'd4, 4'd3, 1'b1, 1'b1, "R4", "R4");
      run(50, 100);
      cfg(3'd3, 4'd3, 1'b1, 1'b1, "R4", "R4");
      run(20, 100);
      cfg(3'd5, 4'd1, 1'b1, 1'b1, "R4", "R4");
      run(20, 100);
      cfg(3'd2, 4'd3, 1'b1, 1'b1, "R4", "R4");
      run(100, 100);
      // R9 and R10: enables gate only their own outputs
      cfg(3'd2, 4'd3, 1'b0, 1'b1, "R9", "R9");
      run(100, 100);
      cfg(3'd2, 4'd3, 1'b1, 1'b0, "R10", "R8");
      run(100, 100);
      // R11: pulse timing with sparse reference ticks
      cfg(3'd2, 4'd2, 1'b1, 1'b1, "R11", "R11");
      run(300, 50);
      // R6/R8: every tap code
      for (int k = 2; k <= 13; k++) begin
         cfg(3'd2, 4'(k), 1'b1, 1'b1, "R6", "R8");
         run((1 << (k-1)) * 2 + 20, 100);
      end
      cfg(3'd2, 4'd15, 1'b1, 1'b1, "R6", "R8");
      run(33000, 100);
      cfg(3'd2, 4'd14, 1'b1, 1'b1, "R6", "R8");
      run(20000, 70);
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

endmodule